// File: doc/BRIEF.md
# Slot Completion and New-Command Status Mailbox

This block carries slot-level status between a host and an embedded scheduling controller. Each side has its own simple register port. In one direction the host announces a freshly filled command-queue slot by writing the slot number. The controller then collects the pending slots as bit words. In the other direction the controller ORs completion bits for finished slots into status words. The host reads those words to learn which slots are done.

Every status word clears when its own side reads it. A bit that arrives in the same cycle as that read survives for the next read. Each direction has a level interrupt that the controller can mask through a small control register. The number of slots is a parameter of up to 128, spread over consecutive 32-bit words.

Top module: `slot_status_mailbox`

## Requirements
- R1: After a synchronous active-high reset, all status bits are zero, both enables are zero, and both interrupts and both read-valid outputs are low.
- R2: A host write to address WORDS (4 by default) with a slot number s below SLOTS sets new-command bit s. A later controller read of word s/32 returns that bit at position s mod 32.
- R3: A controller read of new-command word w returns its content and clears only word w. The other words keep their bits.
- R4: A controller write of a mask to address w below WORDS ORs the mask into completion word w. A host read of word w returns the accumulated bits and clears that word.
- R5: A bit set in the same cycle as a clearing read of its word is not in that read's data. It is returned by the next read.
- R6: Every read is answered with rvalid high for one cycle, one cycle after the read strobe. A read of a word with nothing pending returns zero.
- R7: irq_host is a level signal. It is high one cycle after control bit 0 is set while any completion bit is pending. It is low one cycle after the bit is cleared or nothing is pending.
- R8: irq_ctrl behaves in the same way for control bit 1 and the new-command bits.
- R9: A host write carrying a slot number of SLOTS or more has no effect. So does a host write to any address other than WORDS.
- R10: The control register sits at controller address WORDS. It holds bit 0 (completion interrupt enable) and bit 1 (new-command interrupt enable), and it reads back at the same address with all upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | AW | Host word address |
| h_wdata | input | 32 | Host write data (slot number) |
| h_rdata | output | 32 | Host read data, registered |
| h_rvalid | output | 1 | Host read data valid |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_addr | input | AW | Controller word address |
| c_wdata | input | 32 | Controller write data (completion mask or control) |
| c_rdata | output | 32 | Controller read data, registered |
| c_rvalid | output | 1 | Controller read data valid |
| irq_host | output | 1 | Level interrupt toward the host |
| irq_ctrl | output | 1 | Level interrupt toward the controller |

## Verification
Slot numbers are placed in the first, an inner and the last word, including slot 127. This separates correct word and bit placement from off-by-one decoding and from clearing the wrong word. Completion masks are written twice to one word to show OR accumulation rather than overwrite. Set and clear are issued in the same cycle in both directions, which separates set-after-clear ordering from clear-after-set. Each interrupt is driven with its enable off and pending bits present, then on, then off again, so masking is told apart from a missing or sticky interrupt. Out-of-range slot numbers and writes to the wrong address are followed by reads of every word to confirm they changed nothing.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic cmd_irq_en;
    logic done_irq_en;
  } ssm_ctrl_t;

  function automatic int words_for(input int slots);
    return (slots + WORD_W - 1) / WORD_W;
  endfunction

  function automatic logic [WORD_W-1:0] word_valid_mask(input int slots, input int w);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = ((w * WORD_W + b) < slots);
    end
    return m;
  endfunction

endpackage

// File: rtl/ssm_slot_decode.sv
module ssm_slot_decode #(
  parameter int SLOTS = 128,
  parameter int WORDS = 4
) (
  input  logic                  en,
  input  logic [31:0]           idx,
  output logic [WORDS*32-1:0]   onehot
);
  localparam int TOT = WORDS * 32;

  for (genvar i = 0; i < TOT; i++) begin : g_bit
    if (i < SLOTS) begin : g_live
      assign onehot[i] = en && (idx == 32'(i));
    end else begin : g_pad
      assign onehot[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ssm_bit_bank.sv
module ssm_bit_bank
  import ssm_pkg::*;
#(
  parameter int SLOTS = 128,
  parameter int WORDS = 4,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORDS*32-1:0]   set_vec,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [WORDS*32-1:0]   bits_o,
  output logic [31:0]           rd_word_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [31:0] VMASK = word_valid_mask(SLOTS, w);
    logic [31:0] word_q;
    logic        clr;

    assign clr = rd_en && (rd_addr == AW'(w));

    // clear first, then OR new bits in, so a same-cycle set survives
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else begin
        word_q <= ((clr ? 32'h0 : word_q) | set_vec[w*32 +: 32]) & VMASK;
      end
    end

    assign bits_o[w*32 +: 32] = word_q;
  end

  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_addr == AW'(w)) begin
        rd_word_o = bits_o[w*32 +: 32];
      end
    end
  end

endmodule

// File: rtl/ssm_irq_level.sv
module ssm_irq_level (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pending,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= en && pending;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/slot_status_mailbox.sv
module slot_status_mailbox
  import ssm_pkg::*;
#(
  parameter int SLOTS = 128,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_rvalid,
  input  logic          c_wr,
  input  logic          c_rd,
  input  logic [AW-1:0] c_addr,
  input  logic [31:0]   c_wdata,
  output logic [31:0]   c_rdata,
  output logic          c_rvalid,
  output logic          irq_host,
  output logic          irq_ctrl
);

  localparam int            WORDS     = words_for(SLOTS);
  localparam int            TOT       = WORDS * 32;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(WORDS);

  // new-command direction: host writes slot number, controller reads
  logic [TOT-1:0] cmd_set;
  logic [TOT-1:0] cmd_bits;
  logic [31:0]    cmd_word;
  logic           cmd_any;

  // completion direction: controller writes mask, host reads
  logic [TOT-1:0] done_set;
  logic [TOT-1:0] done_bits;
  logic [31:0]    done_word;
  logic           done_any;

  ssm_ctrl_t   ctrl_q;
  logic [31:0] h_rdata_q;
  logic [31:0] c_rdata_q;
  logic        h_rvalid_q;
  logic        c_rvalid_q;

  ssm_slot_decode #(.SLOTS(SLOTS), .WORDS(WORDS)) u_dec (
    .en     (h_wr && (h_addr == CTRL_ADDR)),
    .idx    (h_wdata),
    .onehot (cmd_set)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_mask
    assign done_set[w*32 +: 32] = (c_wr && (c_addr == AW'(w))) ? c_wdata : 32'h0;
  end

  ssm_bit_bank #(.SLOTS(SLOTS), .WORDS(WORDS), .AW(AW)) u_cmd_bank (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (cmd_set),
    .rd_en     (c_rd),
    .rd_addr   (c_addr),
    .bits_o    (cmd_bits),
    .rd_word_o (cmd_word)
  );

  ssm_bit_bank #(.SLOTS(SLOTS), .WORDS(WORDS), .AW(AW)) u_done_bank (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (done_set),
    .rd_en     (h_rd),
    .rd_addr   (h_addr),
    .bits_o    (done_bits),
    .rd_word_o (done_word)
  );

  assign cmd_any  = |cmd_bits;
  assign done_any = |done_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (c_wr && (c_addr == CTRL_ADDR)) begin
      ctrl_q <= ssm_ctrl_t'(c_wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata_q  <= '0;
      c_rdata_q  <= '0;
      h_rvalid_q <= 1'b0;
      c_rvalid_q <= 1'b0;
    end else begin
      h_rvalid_q <= h_rd;
      c_rvalid_q <= c_rd;
      if (h_rd) begin
        h_rdata_q <= done_word;
      end
      if (c_rd) begin
        c_rdata_q <= (c_addr == CTRL_ADDR) ? {30'h0, ctrl_q} : cmd_word;
      end
    end
  end

  ssm_irq_level u_irq_host (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_q.done_irq_en),
    .pending (done_any),
    .irq_o   (irq_host)
  );

  ssm_irq_level u_irq_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_q.cmd_irq_en),
    .pending (cmd_any),
    .irq_o   (irq_ctrl)
  );

  assign h_rdata  = h_rdata_q;
  assign c_rdata  = c_rdata_q;
  assign h_rvalid = h_rvalid_q;
  assign c_rvalid = c_rvalid_q;

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int SLOTS = 128,
  parameter int AW    = 4,
  parameter int WORDS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                h_wr,
  input logic                h_rd,
  input logic [AW-1:0]       h_addr,
  input logic [31:0]         h_wdata,
  input logic                h_rvalid,
  input logic                c_wr,
  input logic                c_rd,
  input logic [AW-1:0]       c_addr,
  input logic [31:0]         c_wdata,
  input logic                c_rvalid,
  input logic [WORDS*32-1:0] cmd_bits,
  input logic                done_any,
  input logic                cmd_any,
  input logic                done_en,
  input logic                cmd_en,
  input logic                irq_host,
  input logic                irq_ctrl
);
  localparam logic [AW-1:0] CTRL_ADDR  = AW'(WORDS);
  localparam logic [AW-1:0] FULL_WORDS = AW'(SLOTS / 32);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_host && !irq_ctrl && !h_rvalid && !c_rvalid));

  assert_host_rvalid_R6: assert property (@(posedge clk) disable iff (rst)
    h_rd |=> h_rvalid);

  assert_ctrl_rvalid_R6: assert property (@(posedge clk) disable iff (rst)
    c_rd |=> c_rvalid);

  assert_done_set_R4: assert property (@(posedge clk) disable iff (rst)
    (c_wr && (c_addr < FULL_WORDS) && (c_wdata != 32'h0)) |=> done_any);

  assert_irq_host_on_R7: assert property (@(posedge clk) disable iff (rst)
    (done_en && done_any) |=> irq_host);

  assert_irq_host_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (!done_en || !done_any) |=> !irq_host);

  assert_irq_ctrl_on_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_any) |=> irq_ctrl);

  assert_irq_ctrl_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmd_en || !cmd_any) |=> !irq_ctrl);

  assert_bad_slot_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (h_wr && !c_rd && ((h_addr != CTRL_ADDR) || (h_wdata >= 32'(SLOTS))))
      |=> $stable(cmd_bits));
endmodule

bind slot_status_mailbox ssm_checker #(.SLOTS(SLOTS), .AW(AW), .WORDS(WORDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .h_wr     (h_wr),
  .h_rd     (h_rd),
  .h_addr   (h_addr),
  .h_wdata  (h_wdata),
  .h_rvalid (h_rvalid),
  .c_wr     (c_wr),
  .c_rd     (c_rd),
  .c_addr   (c_addr),
  .c_wdata  (c_wdata),
  .c_rvalid (c_rvalid),
  .cmd_bits (cmd_bits),
  .done_any (done_any),
  .cmd_any  (cmd_any),
  .done_en  (ctrl_q.done_irq_en),
  .cmd_en   (ctrl_q.cmd_irq_en),
  .irq_host (irq_host),
  .irq_ctrl (irq_ctrl)
);

// File: tb/slot_status_mailbox_tb_top.sv
`timescale 1ns/1ps
module slot_status_mailbox_tb_top;
  localparam int SLOTS = 128;
  localparam int AW    = 4;
  localparam int WORDS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
  logic [AW-1:0] h_addr = '0, c_addr = '0;
  logic [31:0]   h_wdata = '0, c_wdata = '0;
  logic [31:0]   h_rdata, c_rdata;
  logic          h_rvalid, c_rvalid, irq_host, irq_ctrl;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  slot_status_mailbox #(.SLOTS(SLOTS), .AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_rvalid(c_rvalid),
    .irq_host(irq_host), .irq_ctrl(irq_ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic ctl_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); h_rd = 1; h_addr = a;
    @(negedge clk); h_rd = 0;
    chk("R6 host rvalid", 32'(h_rvalid), 32'd1);
    d = h_rdata;
  endtask

  task automatic ctl_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); c_rd = 1; c_addr = a;
    @(negedge clk); c_rd = 0;
    chk("R6 ctrl rvalid", 32'(c_rvalid), 32'd1);
    d = c_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_host", 32'(irq_host), 0);
    chk("R1 irq_ctrl", 32'(irq_ctrl), 0);
    chk("R1 h_rvalid", 32'(h_rvalid), 0);
    chk("R1 c_rvalid", 32'(c_rvalid), 0);
    ctl_rd(AW'(WORDS), d);
    chk("R1 ctrl reg", d, 0);
    for (int w = 0; w < WORDS; w++) begin
      host_rd(AW'(w), d); chk("R1 done word", d, 0);
      ctl_rd(AW'(w), d);  chk("R1 cmd word", d, 0);
    end
  endtask

  task automatic t_cmd_path();
    logic [31:0] d;
    host_wr(AW'(WORDS), 5);
    host_wr(AW'(WORDS), 40);
    host_wr(AW'(WORDS), 127);
    ctl_rd(0, d); chk("R2 slot 5", d, 32'h20);
    ctl_rd(0, d); chk("R3 word0 cleared", d, 0);
    ctl_rd(1, d); chk("R3 word1 kept slot 40", d, 32'h100);
    ctl_rd(3, d); chk("R2 slot 127", d, 32'h8000_0000);
    ctl_rd(3, d); chk("R3 word3 cleared", d, 0);
  endtask

  task automatic t_done_path();
    logic [31:0] d;
    ctl_wr(1, 32'hA5);
    ctl_wr(1, 32'hF00);
    host_rd(1, d); chk("R4 OR accumulate", d, 32'hFA5);
    host_rd(1, d); chk("R4 cleared on read", d, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    ctl_wr(0, 32'h1);
    @(negedge clk); h_rd = 1; h_addr = 0; c_wr = 1; c_addr = 0; c_wdata = 32'h2;
    @(negedge clk); h_rd = 0; c_wr = 0;
    chk("R5 done read old", h_rdata, 32'h1);
    host_rd(0, d); chk("R5 done new bit kept", d, 32'h2);
    host_wr(AW'(WORDS), 3);
    @(negedge clk); c_rd = 1; c_addr = 0; h_wr = 1; h_addr = AW'(WORDS); h_wdata = 4;
    @(negedge clk); c_rd = 0; h_wr = 0;
    chk("R5 cmd read old", c_rdata, 32'h8);
    ctl_rd(0, d); chk("R5 cmd new bit kept", d, 32'h10);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    ctl_wr(0, 32'h10);
    @(negedge clk);
    chk("R7 masked", 32'(irq_host), 0);
    ctl_wr(AW'(WORDS), 32'h1);
    @(negedge clk);
    chk("R7 raised", 32'(irq_host), 1);
    chk("R8 not raised", 32'(irq_ctrl), 0);
    host_rd(0, d);
    @(negedge clk);
    chk("R7 drops when cleared", 32'(irq_host), 0);
    host_wr(AW'(WORDS), 9);
    @(negedge clk);
    chk("R8 masked", 32'(irq_ctrl), 0);
    ctl_wr(AW'(WORDS), 32'h3);
    @(negedge clk);
    chk("R8 raised", 32'(irq_ctrl), 1);
    ctl_wr(AW'(WORDS), 32'h0);
    @(negedge clk);
    chk("R8 disabled while pending", 32'(irq_ctrl), 0);
    ctl_rd(0, d); chk("R8 pending slot 9", d, 32'h200);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    host_wr(AW'(WORDS), 200);
    host_wr(AW'(WORDS), 128);
    host_wr(0, 32'h3);
    host_wr(AW'(WORDS + 1), 32'h2);
    for (int w = 0; w < WORDS; w++) begin
      ctl_rd(AW'(w), d); chk("R9 no cmd bit", d, 0);
      host_rd(AW'(w), d); chk("R9 no done bit", d, 0);
    end
  endtask

  task automatic t_ctrl_reg();
    logic [31:0] d;
    ctl_wr(AW'(WORDS), 32'h3);
    ctl_rd(AW'(WORDS), d); chk("R10 both enables", d, 32'h3);
    ctl_wr(AW'(WORDS), 32'hFFFF_FFFE);
    ctl_rd(AW'(WORDS), d); chk("R10 upper bits dropped", d, 32'h2);
    ctl_wr(AW'(WORDS), 0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    host_rd(2, d); chk("R6 empty host read", d, 0);
    chk("R6 rvalid one cycle", 32'(h_rvalid), 1);
    @(negedge clk);
    chk("R6 rvalid drops", 32'(h_rvalid), 0);
    ctl_rd(2, d); chk("R6 empty ctrl read", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cmd_path();
    t_done_path();
    t_same_cycle();
    t_irq();
    t_ignored();
    t_ctrl_reg();
    t_empty();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule